// File: doc/BRIEF.md
# Mask-Driven Bit Gather, Scatter and Partition Unit

This block rearranges the bits of one data word under the control of a second word used as a free-form selection mask. No offset or length fields are used. It provides three operations. The gather operation collects the data bits that sit under mask ones and packs them at the low end of the result. The scatter operation takes data bits from the low end and places them, in order, at the mask-one positions. The partition operation moves the mask-selected bits to the high end and the unselected bits to the low end, and it keeps the original relative order inside each of the two groups.

The unit works serially and handles one mask position per clock. A caller raises `start` for one cycle while the unit is idle, and at the same time presents the operands and the operation code. `busy` stays high while the operation runs. `done` rises for a single cycle when `result` holds the answer. The result stays on the port until the next operation finishes.

Top module: `bitmask_permuter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `done` and `busy` are 0 and `result` is all zeros.
- R2: If `start` is 1 at a rising edge where `busy` is 0, the operands are captured and `busy` goes to 1 at that edge. `busy` returns to 0 and `done` goes to 1 at the W-th rising edge after the capturing edge. A start that comes in the cycle where `done` is 1 is accepted.
- R3: `done` is 1 for exactly one cycle per operation. `result` does not change except at the edge that raises `done`.
- R4: A `start` that comes while `busy` is 1 is ignored. Its operands have no effect on the result of the operation in progress, and they do not change when `done` arrives.
- R5: With `op` = 0 (gather), the data bits at mask-one positions are packed in ascending order into the result, starting at bit 0. All higher result bits are 0.
- R6: With `op` = 1 (scatter), the j-th mask-one position, counting from bit 0, receives data bit j. Result bits at mask-zero positions are 0. Data bits at or above the mask's popcount are dropped.
- R7: With `op` = 2 or 3 (partition), the bits at mask-one positions fill the top of the result and the bits at mask-zero positions fill the bottom. Each group keeps its ascending order.
- R8: With a mask of all zeros, gather and scatter return 0 and partition returns the data unchanged. With a mask of all ones, all three operations return the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation (taken only while idle) |
| op | input | 2 | 0 gather, 1 scatter, 2 or 3 partition |
| src | input | W | Data word |
| mask | input | W | Selection mask |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Result of the last completed operation |

## Verification
The bench goes after the empty and full masks. A unit with a bad end case would return stale data for gather, or would shift the partition result by the full word width and get a nonzero value where the data itself is expected. Sparse masks with bits at both ends catch a pointer that is off by one: gather would then drop the top bit, and scatter would read data bit 1 in place of bit 0. The bench pulses `start` while the unit is busy, which exposes a unit that recaptures operands in the middle of a run. It also starts a new operation in the `done` cycle, which exposes a unit that inserts an idle cycle or loses the request. Both partition codes are run with masks where the two groups are unequal, so an order reversal or a wrong group boundary changes the result.

// File: rtl/bitmask_permuter.sv
module bitmask_permuter #(
  parameter int W = 64,
  localparam int IW = $clog2(W),
  localparam int CW = IW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);

  logic          busy_q, done_q;
  logic [1:0]    op_q;
  logic [W-1:0]  src_q, mask_q, sel_q, uns_q, dep_q, res_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] nsel_q, nuns_q;

  logic          m_bit, s_bit, last;
  logic [W-1:0]  sel_n, uns_n, dep_n, cen_n, fin_n;
  logic [CW-1:0] nsel_n, nuns_n;

  assign m_bit  = mask_q[idx_q];
  assign s_bit  = src_q[idx_q];
  assign last   = (idx_q == IW'(W - 1));
  assign nsel_n = nsel_q + CW'(m_bit);
  assign nuns_n = nuns_q + CW'(!m_bit);

  always_comb begin
    sel_n = sel_q;
    uns_n = uns_q;
    dep_n = dep_q;
    if (m_bit) begin
      sel_n[nsel_q[IW-1:0]] = s_bit;
      dep_n[idx_q]          = src_q[nsel_q[IW-1:0]];
    end else begin
      uns_n[nuns_q[IW-1:0]] = s_bit;
    end
  end

  assign cen_n = (sel_n << nuns_n) | uns_n;

  always_comb begin
    case (op_q)
      2'd0:    fin_n = sel_n;
      2'd1:    fin_n = dep_n;
      default: fin_n = cen_n;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= '0;
      src_q  <= '0;
      mask_q <= '0;
      idx_q  <= '0;
      sel_q  <= '0;
      uns_q  <= '0;
      dep_q  <= '0;
      nsel_q <= '0;
      nuns_q <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        sel_q  <= sel_n;
        uns_q  <= uns_n;
        dep_q  <= dep_n;
        nsel_q <= nsel_n;
        nuns_q <= nuns_n;
        idx_q  <= idx_q + IW'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= fin_n;
        end
      end else if (start) begin
        busy_q <= 1'b1;
        op_q   <= op;
        src_q  <= src;
        mask_q <= mask;
        idx_q  <= '0;
        sel_q  <= '0;
        uns_q  <= '0;
        dep_q  <= '0;
        nsel_q <= '0;
        nuns_q <= '0;
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));

  p_gather_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 2'd0) |-> ($countones(result) <= $countones(mask_q)));

  p_scatter_in_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 2'd1) |-> ((result & ~mask_q) == '0));

  p_partition_keeps_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q[1]) |-> ($countones(result) == $countones(src_q)));

endmodule

// File: tb/bitmask_permuter_test.sv
module bitmask_permuter_test;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = 2'd0;
  logic [W-1:0] src = '0;
  logic [W-1:0] mask = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_tag = "R5";
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  bitmask_permuter #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src(src),
    .mask(mask), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [W-1:0] ref_gather(logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[k] = s[i]; k++; end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_scatter(logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[i] = s[k]; k++; end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_partition(logic [W-1:0] s, logic [W-1:0] m);
    logic q[$];
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) if (!m[i]) q.push_back(s[i]);
    for (int i = 0; i < W; i++) if (m[i]) q.push_back(s[i]);
    for (int j = 0; j < W; j++) r[j] = q[j];
    return r;
  endfunction

  function automatic logic [W-1:0] ref_any(logic [1:0] o, logic [W-1:0] s, logic [W-1:0] m);
    if (o == 2'd0) return ref_gather(s, m);
    if (o == 2'd1) return ref_scatter(s, m);
    return ref_partition(s, m);
  endfunction

  logic         m_busy = 1'b0, m_done = 1'b0;
  int           m_cnt = 0;
  logic [W-1:0] m_res = '0, m_pend = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_res <= '0; m_cnt <= 0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        if (m_cnt == W - 1) begin
          m_busy <= 1'b0; m_done <= 1'b1; m_res <= m_pend;
        end else m_cnt <= m_cnt + 1;
      end else if (start) begin
        m_busy <= 1'b1; m_cnt <= 0; m_pend <= ref_any(op, src, mask);
      end
    end
  end

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R2", {63'd0, busy}, {63'd0, m_busy});
      check("R3", {63'd0, done}, {63'd0, m_done});
      check(done ? cur_tag : "R3", result, m_res);
    end
    if (cycles > 200000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<200000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [63:0] next_rand();
    seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
    return seed;
  endfunction

  task automatic run_op(logic [1:0] o, logic [W-1:0] s, logic [W-1:0] m, string tag);
    @(negedge clk);
    cur_tag = tag; op = o; src = s; mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {62'd0, busy, done}, 64'd0);
    check("R1", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {62'd0, busy, done}, 64'd0);
    check("R1", result, '0);

    run_op(2'd0, 64'hDEAD_BEEF_0123_4567, 64'hF0F0_00FF_1234_8001, "R5");
    run_op(2'd0, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, "R5");
    run_op(2'd1, 64'h0000_0000_0000_00B5, 64'h8421_0000_F000_0013, "R6");
    run_op(2'd1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0003, "R6");
    run_op(2'd2, 64'hDEAD_BEEF_0123_4567, 64'h0000_0000_FFFF_0000, "R7");
    run_op(2'd3, 64'h0F1E_2D3C_4B5A_6978, 64'hC000_0000_0000_0005, "R7");
    for (int n = 0; n < 6; n++) run_op(2'(n % 3), next_rand(), next_rand(), n % 3 == 0 ? "R5" : (n % 3 == 1 ? "R6" : "R7"));
    for (int o = 0; o < 3; o++) begin
      run_op(2'(o), 64'hA5C3_1234_FEDC_0987, '0, "R8");
      run_op(2'(o), 64'hA5C3_1234_FEDC_0987, '1, "R8");
    end

    @(negedge clk);
    cur_tag = "R4"; op = 2'd0; src = 64'h1357_9BDF_2468_ACE0; mask = 64'h00FF_FF00_0F0F_F0F0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    op = 2'd2; src = '1; mask = 64'h1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W) @(negedge clk);

    @(negedge clk);
    cur_tag = "R2"; op = 2'd1; src = next_rand(); mask = next_rand(); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    op = 2'd2; src = next_rand(); mask = next_rand(); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule